// File: doc/BRIEF.md
# Orientation-Remapping Display Scan-Out

This block walks a monochrome frame buffer of 8 pages by 128 columns. It delivers the 8-pixel column bytes in the order a panel consumes them: every column of the top display page first, then the next page, down to the last page. Each buffer byte holds eight vertically stacked pixels, and bit 0 is the top pixel of the page. Two orientation flags decide where each displayed byte comes from. A horizontal flip mirrors the column index. A vertical flip mirrors the page index and also reverses the bit order inside the byte, so the picture stays upright pixel by pixel.

A start strobe launches one full scan. The block samples the orientation, display-enable and invert inputs at the accepted start and holds them for the whole scan. It reads the buffer through a synchronous port with one cycle of read latency. Each output byte appears with a valid flag and with the display page and column it belongs to. A one-cycle done pulse follows the scan. When the display is disabled, the scan still runs its full length, but it issues no reads and emits no pixel beats. Only the latched invert (background) flag is then meaningful to the panel logic downstream.

Top module: `oled_scanout`

## Requirements
- R1: While `rst` is high, and in the cycle after the edge that samples it, `mem_rd_en`, `pix_valid` and `done` are 0 and `invert_o` is 0. Reset aborts a scan in progress, and the latched orientation returns to no horizontal flip and no vertical flip.
- R2: A scan with the display enabled emits exactly 1024 beats. `pix_page`/`pix_col` run 0/0, 0/1 … 0/127, 1/0 … 7/127, one beat per cycle with no gaps.
- R3: The read address is `src_page*128 + src_col`. The first read is issued in the cycle after the edge that accepts `start`. Each `pix_valid` beat carries the data returned for the read issued one cycle earlier, so the first beat appears 2 cycles after the cycle in which `start` was driven.
- R4: With `seg_rev`=0 and `com_rev`=0, the beat at (p,c) is buffer byte (p,c) unchanged.
- R5: With `seg_rev`=0 and `com_rev`=1, the beat at (p,c) is buffer byte (7-p,c) with bit i moved to bit 7-i.
- R6: With `seg_rev`=1 and `com_rev`=1, the beat at (p,c) is buffer byte (7-p,127-c), bit-reversed.
- R7: With `seg_rev`=1 and `com_rev`=0, the beat at (p,c) is buffer byte (p,127-c), not bit-reversed.
- R8: With `disp_on`=0 at start, the scan issues no reads and no `pix_valid` beats, but it still takes its full length and still ends with `done`.
- R9: `done` is high for exactly one cycle per scan, 1026 cycles after the cycle in which `start` was driven. That is the cycle right after the last beat.
- R10: A `start`, or a change of `seg_rev`, `com_rev`, `disp_on` or `invert`, that arrives during a scan has no effect. The running scan keeps its order and content, emits no extra beats and produces a single `done`.
- R11: `invert_o` equals the `invert` value sampled at the accepted start and holds that value until the next accepted start or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one scan (ignored while a scan runs) |
| seg_rev | input | 1 | Horizontal flip: mirror the column index |
| com_rev | input | 1 | Vertical flip: mirror the page index and reverse the bits in the byte |
| disp_on | input | 1 | Display enable; 0 suppresses reads and pixel beats |
| invert | input | 1 | Global invert flag to latch |
| mem_rd_en | output | 1 | Buffer read enable |
| mem_addr | output | 10 | Buffer read address (page*128 + column) |
| mem_rd_data | input | 8 | Read data, valid one cycle after `mem_rd_en` |
| pix_valid | output | 1 | Pixel column byte valid |
| pix_data | output | 8 | Pixel column byte, bit 0 at the top |
| pix_page | output | 3 | Display page of the beat |
| pix_col | output | 7 | Display column of the beat |
| invert_o | output | 1 | Latched invert flag |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
A corrupted scan counter shows up on `mem_addr` in the same cycle and on the `pix_page`/`pix_col` tags one cycle later. A beat that is skipped or repeated also moves `done` away from its fixed distance from `start`. A wrong latched orientation bit changes the address of every read, so the first read of the scan already shows it. A lost bit-reversal select shows in the data byte of the first beat whose source byte is not a palindrome. A stale display-enable or invert bit is visible at the ports for the whole scan.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int unsigned DEF_PAGES = 8;
    localparam int unsigned DEF_COLS  = 128;
    localparam int unsigned DEF_PIX   = 8;

    // Scan-wide settings captured on an accepted start
    typedef struct packed {
        logic seg_rev;   // mirror column index
        logic com_rev;   // mirror page index and reverse bits
        logic disp_on;   // emit reads and beats
        logic invert;    // background invert flag
    } scan_cfg_t;

    localparam scan_cfg_t CFG_RESET = '{seg_rev: 1'b0, com_rev: 1'b0,
                                        disp_on: 1'b0, invert: 1'b0};

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } scan_state_t;

endpackage

// File: rtl/scan_seq.sv
module scan_seq
    import scan_pkg::*;
#(
    parameter int unsigned PAGES = DEF_PAGES,
    parameter int unsigned COLS  = DEF_COLS,
    localparam int unsigned PG_W  = $clog2(PAGES),
    localparam int unsigned COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  scan_cfg_t        cfg_in,
    output logic             busy,
    output logic             last,
    output logic [PG_W-1:0]  page,
    output logic [COL_W-1:0] col,
    output scan_cfg_t        cfg
);
    localparam logic [PG_W-1:0]  PG_LAST  = PG_W'(PAGES - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

    scan_state_t state;

    assign busy = (state == ST_RUN);
    assign last = busy && (page == PG_LAST) && (col == COL_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            page  <= '0;
            col   <= '0;
            cfg   <= CFG_RESET;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        page  <= '0;
                        col   <= '0;
                        cfg   <= cfg_in;
                    end
                end
                ST_RUN: begin
                    if (last) begin
                        state <= ST_IDLE;
                    end else if (col == COL_LAST) begin
                        col  <= '0;
                        page <= page + 1'b1;
                    end else begin
                        col <= col + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/scan_map.sv
module scan_map
    import scan_pkg::*;
#(
    parameter int unsigned PAGES = DEF_PAGES,
    parameter int unsigned COLS  = DEF_COLS,
    localparam int unsigned PG_W   = $clog2(PAGES),
    localparam int unsigned COL_W  = $clog2(COLS),
    localparam int unsigned ADDR_W = $clog2(PAGES * COLS)
) (
    input  logic [PG_W-1:0]   page,
    input  logic [COL_W-1:0]  col,
    input  scan_cfg_t         cfg,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [PG_W-1:0]  PG_LAST  = PG_W'(PAGES - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

    logic [PG_W-1:0]  src_page;
    logic [COL_W-1:0] src_col;

    always_comb begin
        src_page = cfg.com_rev ? (PG_LAST - page) : page;
        src_col  = cfg.seg_rev ? (COL_LAST - col) : col;
        addr     = ADDR_W'(src_page) * ADDR_W'(COLS) + ADDR_W'(src_col);
    end
endmodule

// File: rtl/scan_fmt.sv
module scan_fmt
    import scan_pkg::*;
#(
    parameter int unsigned PAGES = DEF_PAGES,
    parameter int unsigned COLS  = DEF_COLS,
    parameter int unsigned PIX   = DEF_PIX,
    localparam int unsigned PG_W  = $clog2(PAGES),
    localparam int unsigned COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_issue,
    input  logic             last,
    input  logic [PG_W-1:0]  page,
    input  logic [COL_W-1:0] col,
    input  logic             flip_bits,
    input  logic [PIX-1:0]   rd_data,
    output logic             pix_valid,
    output logic [PIX-1:0]   pix_data,
    output logic [PG_W-1:0]  pix_page,
    output logic [COL_W-1:0] pix_col,
    output logic             done
);
    logic           valid_q, last_q, flip_q;
    logic [PIX-1:0] swapped;

    // Mirror the pixel column: top pixel becomes bottom pixel
    for (genvar i = 0; i < PIX; i++) begin : g_swap
        assign swapped[i] = rd_data[PIX-1-i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            last_q   <= 1'b0;
            flip_q   <= 1'b0;
            done     <= 1'b0;
            pix_page <= '0;
            pix_col  <= '0;
        end else begin
            valid_q  <= rd_issue;
            last_q   <= last;
            flip_q   <= flip_bits;
            done     <= last_q;
            pix_page <= page;
            pix_col  <= col;
        end
    end

    assign pix_valid = valid_q;
    assign pix_data  = !valid_q ? '0 : (flip_q ? swapped : rd_data);
endmodule

// File: rtl/oled_scanout.sv
module oled_scanout
    import scan_pkg::*;
#(
    parameter int unsigned PAGES = DEF_PAGES,
    parameter int unsigned COLS  = DEF_COLS,
    parameter int unsigned PIX   = DEF_PIX,
    localparam int unsigned PG_W   = $clog2(PAGES),
    localparam int unsigned COL_W  = $clog2(COLS),
    localparam int unsigned ADDR_W = $clog2(PAGES * COLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              seg_rev,
    input  logic              com_rev,
    input  logic              disp_on,
    input  logic              invert,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [PIX-1:0]    mem_rd_data,
    output logic              pix_valid,
    output logic [PIX-1:0]    pix_data,
    output logic [PG_W-1:0]   pix_page,
    output logic [COL_W-1:0]  pix_col,
    output logic              invert_o,
    output logic              done
);
    scan_cfg_t        cfg_in, cfg;
    logic             busy, last;
    logic [PG_W-1:0]  page;
    logic [COL_W-1:0] col;

    assign cfg_in = '{seg_rev: seg_rev, com_rev: com_rev,
                      disp_on: disp_on, invert: invert};

    scan_seq #(.PAGES(PAGES), .COLS(COLS)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cfg_in (cfg_in),
        .busy   (busy),
        .last   (last),
        .page   (page),
        .col    (col),
        .cfg    (cfg)
    );

    scan_map #(.PAGES(PAGES), .COLS(COLS)) u_map (
        .page (page),
        .col  (col),
        .cfg  (cfg),
        .addr (mem_addr)
    );

    assign mem_rd_en = busy && cfg.disp_on;
    assign invert_o  = cfg.invert;

    scan_fmt #(.PAGES(PAGES), .COLS(COLS), .PIX(PIX)) u_fmt (
        .clk       (clk),
        .rst       (rst),
        .rd_issue  (mem_rd_en),
        .last      (last),
        .page      (page),
        .col       (col),
        .flip_bits (cfg.com_rev),
        .rd_data   (mem_rd_data),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .pix_page  (pix_page),
        .pix_col   (pix_col),
        .done      (done)
    );
endmodule

// File: rtl/scan_chk.sv
module scan_chk #(
    parameter int unsigned PAGES = 8,
    parameter int unsigned COLS  = 128,
    localparam int unsigned PG_W  = $clog2(PAGES),
    localparam int unsigned COL_W = $clog2(COLS)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             mem_rd_en,
    input logic             pix_valid,
    input logic [PG_W-1:0]  pix_page,
    input logic [COL_W-1:0] pix_col,
    input logic             invert_o,
    input logic             done
);
    localparam logic [PG_W-1:0]  PG_LAST  = PG_W'(PAGES - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

    // R2: columns advance by one inside a page
    p_col_step_r2: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_col != COL_LAST)
        |=> (pix_valid && pix_col == $past(pix_col) + 1'b1 && $stable(pix_page)));

    // R2: end of a page wraps to column 0 of the next page
    p_page_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_col == COL_LAST && pix_page != PG_LAST)
        |=> (pix_valid && pix_col == '0 && pix_page == $past(pix_page) + 1'b1));

    // R3: every beat follows a read one cycle earlier
    p_latency_r3: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> $past(mem_rd_en));

    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: no read is in flight when done fires
    p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_rd_en && !pix_valid));

    // R10: reads only begin after a start strobe
    p_rd_start_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rd_en) |-> $past(start));

    // R11: invert flag holds during a scan
    p_invert_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && $past(mem_rd_en)) |-> $stable(invert_o));
endmodule

bind oled_scanout scan_chk #(.PAGES(PAGES), .COLS(COLS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mem_rd_en (mem_rd_en),
    .pix_valid (pix_valid),
    .pix_page  (pix_page),
    .pix_col   (pix_col),
    .invert_o  (invert_o),
    .done      (done)
);

// File: tb/sim_oled_scanout.sv
module sim_oled_scanout;
    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic       rst = 1'b1, start = 1'b0;
    logic       seg_rev = 1'b0, com_rev = 1'b0, disp_on = 1'b0, invert = 1'b0;
    logic       mem_rd_en;
    logic [9:0] mem_addr;
    logic [7:0] mem_rd_data = '0;
    logic       pix_valid;
    logic [7:0] pix_data;
    logic [2:0] pix_page;
    logic [6:0] pix_col;
    logic       invert_o, done;

    oled_scanout u0 (
        .clk(clk), .rst(rst), .start(start),
        .seg_rev(seg_rev), .com_rev(com_rev), .disp_on(disp_on), .invert(invert),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_page(pix_page),
        .pix_col(pix_col), .invert_o(invert_o), .done(done)
    );

    // Buffer content is a function of the address
    function automatic logic [7:0] fmem(input int a);
        return 8'((a * 37) ^ (a >> 3) ^ 8'h5A);
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= fmem(int'(mem_addr));

    int n_chk = 0, n_fail = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected model
    bit e_seg, e_com;
    int beats, reads, dones, done_cyc, first_cyc;

    function automatic int exp_addr(input int idx);
        int p = idx / 128, c = idx % 128;
        int sp = e_com ? 7 - p : p;
        int sc = e_seg ? 127 - c : c;
        return sp * 128 + sc;
    endfunction

    function automatic logic [7:0] exp_byte(input int idx);
        logic [7:0] b = fmem(exp_addr(idx));
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return e_com ? r : b;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_rd_en) begin
                chk(int'(mem_addr) == exp_addr(reads), "R3 read address",
                    mem_addr, exp_addr(reads));
                reads++;
            end
            if (pix_valid) begin
                logic [17:0] act, expv;
                string tag;
                tag = e_com ? (e_seg ? "R6 beat (R2 order)" : "R5 beat (R2 order)")
                            : (e_seg ? "R7 beat (R2 order)" : "R4 beat (R2 order)");
                if (beats == 0) first_cyc = cyc;
                act  = {pix_page, pix_col, pix_data};
                expv = {3'(beats / 128), 7'(beats % 128), exp_byte(beats)};
                chk(act == expv, tag, act, expv);
                beats++;
            end
            if (done) begin
                dones++;
                done_cyc = cyc;
            end
        end
    end

    task automatic arm(input logic [3:0] v);
        e_seg = v[3]; e_com = v[2];
        beats = 0; reads = 0; dones = 0; done_cyc = -1; first_cyc = -1;
    endtask

    // {seg_rev, com_rev, disp_on, invert}
    localparam logic [3:0] VEC [6] = '{4'b0010, 4'b0111, 4'b1110, 4'b1011, 4'b0001, 4'b1100};

    task automatic run_scan(input logic [3:0] v);
        int t0;
        arm(v);
        @(negedge clk);
        {seg_rev, com_rev, disp_on, invert} = v;
        start = 1'b1; t0 = cyc;
        @(negedge clk); start = 1'b0;
        repeat (300) @(negedge clk);
        // R10: restart attempt and input changes mid-scan
        {seg_rev, com_rev, disp_on, invert} = ~v;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(invert_o == v[0], "R11 invert held mid-scan", invert_o, v[0]);
        repeat (920) @(negedge clk);
        chk(dones == 1, "R9 single done", dones, 1);
        chk(done_cyc - t0 == 1026, "R9 done timing", done_cyc - t0, 1026);
        chk(beats == (v[1] ? 1024 : 0), v[1] ? "R2 beat count (R10)" : "R8 no beats",
            beats, v[1] ? 1024 : 0);
        chk(reads == (v[1] ? 1024 : 0), v[1] ? "R3 read count" : "R8 no reads",
            reads, v[1] ? 1024 : 0);
        if (v[1]) chk(first_cyc - t0 == 2, "R3 first beat latency", first_cyc - t0, 2);
        chk(invert_o == v[0], "R11 invert after scan", invert_o, v[0]);
        chk(!pix_valid && !mem_rd_en, "R10 no restart", {pix_valid, mem_rd_en}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({mem_rd_en, pix_valid, done, invert_o} == 4'b0, "R1 in reset",
            {mem_rd_en, pix_valid, done, invert_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({mem_rd_en, pix_valid, done, invert_o} == 4'b0, "R1 after reset",
            {mem_rd_en, pix_valid, done, invert_o}, 0);

        for (int k = 0; k < 6; k++) run_scan(VEC[k]);

        // R1: reset during a scan
        arm(4'b0111);
        @(negedge clk);
        {seg_rev, com_rev, disp_on, invert} = 4'b0111;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (100) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk({mem_rd_en, pix_valid, done, invert_o} == 4'b0, "R1 reset aborts scan",
            {mem_rd_en, pix_valid, done, invert_o}, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk(!mem_rd_en && !pix_valid, "R1 stays idle", {mem_rd_en, pix_valid}, 0);
        run_scan(4'b0010);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule